// File: doc/BRIEF.md
# Sample Pacing Divisor Calculator

This block turns requested sampling periods into divisors that a set of hardware pacing counters can actually load. A conversion period, a scan period and an output-DAC update interval arrive as counts of a fixed base time unit. Each one is divided by that unit under a chosen rounding rule. The conversion and scan results are then forced into the range the counters can reach. The block reports the divisors and the periods they really give, so that software or a sequencer can see how far the result is from the request.

A single multi-cycle restoring divider is shared by the three divisions. It runs one quotient bit per clock. A start pulse latches every input and begins a job. A one-cycle done pulse marks the moment all outputs are updated. The outputs then hold until the done pulse of the next job. The scan range depends on the clamped conversion divisor times the channel-list length, so the clamp stage runs in two registered steps.

Top module: `pace_divisor_calc`

## Requirements
- R1: With round_mode 2'b01 (up) a divisor starts from ceil(req/BASE), with 2'b10 (down) from floor(req/BASE), and with 2'b00 (nearest) from floor((req + floor(BASE/2))/BASE).
- R2: round_mode 2'b11 gives the same results as nearest (2'b00).
- R3: When conv_timed is 1, conv_div is the rounded conversion divisor clamped to the range 3 to 2^CNT_W + 2, and conv_period equals conv_div × BASE.
- R4: When conv_timed is 0, conv_div and conv_period are both 0.
- R5: When scan_timed and conv_timed are both 1, scan_div is the rounded scan divisor clamped to the range conv_div × nchan to conv_div × nchan + 2^CNT_W − 2. The lower bound wins if the two cross. scan_period equals scan_div × BASE.
- R6: When scan_timed is 1 and conv_timed is 0, scan_div is the rounded scan divisor clamped to the range 2 to 2^CNT_W + 1.
- R7: When scan_timed is 0, scan_div and scan_period are both 0.
- R8: dac_div equals the rounded DAC divisor minus 2, or 0 when the rounded value is below 2.
- R9: done is high for exactly one cycle per job. The outputs change only in the cycle where done is high and hold otherwise.
- R10: A start pulse while a job is running is ignored. Inputs are latched at the accepted start, so later input changes do not affect that job.
- R11: After reset, done and every divisor and period output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; accepted only while idle |
| round_mode | input | 2 | 00 nearest, 01 up, 10 down, 11 nearest |
| conv_timed | input | 1 | Conversion is paced by the timer |
| scan_timed | input | 1 | Scan start is paced by the timer |
| nchan | input | NCH_W (16) | Channel-list length |
| conv_req | input | REQ_W (32) | Requested conversion period in base units |
| scan_req | input | REQ_W (32) | Requested scan period in base units |
| dac_req | input | REQ_W (32) | Requested output-DAC interval in base units |
| done | output | 1 | One-cycle pulse when the outputs are updated |
| conv_div | output | WIDE_W (48) | Clamped conversion divisor |
| conv_period | output | PER_W (53) | Achieved conversion period |
| scan_div | output | WIDE_W (48) | Clamped scan divisor |
| scan_period | output | PER_W (53) | Achieved scan period |
| dac_div | output | REQ_W+1 (33) | Output-DAC interval divisor |

## Verification
The main function is tried with random requests drawn from three magnitude bands:
- Tiny values land on the lower clamps.
- Mid-range values pass through unclamped, which exposes rounding errors.
- Full-width values hit the upper clamps.

Directed cases sit on the rounding boundaries: a remainder just below and just above half the base, and a zero request. These tell the up, down and nearest rules apart and show that mode 11 matches nearest. Channel counts of zero and above and both states of each pacing flag separate the two scan clamp ranges from the disabled outputs. DAC requests below two base units test the saturation at zero. A second start with different inputs during a running job shows that inputs are latched and the second start is dropped.

// File: rtl/pace_pkg.sv
package pace_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_UP   = 2'b01,
    RND_DOWN = 2'b10,
    RND_ALT  = 2'b11
  } round_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX_CONV,
    ST_FIX_SCAN
  } calc_state_e;

  localparam int NUM_JOBS = 3;
  localparam int JOB_CONV = 0;
  localparam int JOB_SCAN = 1;
  localparam int JOB_DAC  = 2;

endpackage

// File: rtl/pace_round_adj.sv
module pace_round_adj
  import pace_pkg::*;
#(
  parameter int REQ_W = 32,
  parameter int BASE  = 25
) (
  input  logic [REQ_W-1:0] req,
  input  round_mode_e      mode,
  output logic [REQ_W:0]   num
);
  localparam logic [REQ_W:0] UP_BIAS   = (REQ_W+1)'(BASE - 1);
  localparam logic [REQ_W:0] NEAR_BIAS = (REQ_W+1)'(BASE / 2);

  logic [REQ_W:0] bias;

  always_comb begin
    case (mode)
      RND_UP:   bias = UP_BIAS;
      RND_DOWN: bias = '0;
      default:  bias = NEAR_BIAS;
    endcase
    num = {1'b0, req} + bias;
  end
endmodule

// File: rtl/pace_divider.sv
module pace_divider #(
  parameter int DIV_W   = 33,
  parameter int DIVISOR = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] dividend,
  output logic             fin,
  output logic [DIV_W-1:0] quotient
);
  localparam int R_W = $clog2(DIVISOR + 1);
  localparam int C_W = $clog2(DIV_W + 1);
  localparam logic [R_W:0] DVS = (R_W+1)'(DIVISOR);

  logic [R_W-1:0] rem;
  logic [C_W-1:0] cnt;
  logic           busy;
  logic [R_W:0]   shifted;
  logic [R_W:0]   diff;

  assign shifted = {rem, quotient[DIV_W-1]};
  assign diff    = shifted - DVS;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      fin      <= 1'b0;
      rem      <= '0;
      cnt      <= '0;
      quotient <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        busy     <= 1'b1;
        quotient <= dividend;
        rem      <= '0;
        cnt      <= C_W'(DIV_W);
      end else if (busy) begin
        if (shifted >= DVS) begin
          rem      <= diff[R_W-1:0];
          quotient <= {quotient[DIV_W-2:0], 1'b1};
        end else begin
          rem      <= shifted[R_W-1:0];
          quotient <= {quotient[DIV_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == C_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pace_clamp.sv
module pace_clamp #(
  parameter int DIV_W  = 33,
  parameter int NCH_W  = 16,
  parameter int CNT_W  = 24,
  parameter int WIDE_W = 48
) (
  input  logic              conv_timed,
  input  logic              scan_timed,
  input  logic [NCH_W-1:0]  nchan,
  input  logic [DIV_W-1:0]  conv_q,
  input  logic [DIV_W-1:0]  scan_q,
  input  logic [WIDE_W-1:0] conv_held,
  output logic [WIDE_W-1:0] conv_c,
  output logic [WIDE_W-1:0] scan_c
);
  localparam logic [WIDE_W-1:0] CNT_MAX   = WIDE_W'((64'd1 << CNT_W) - 64'd1);
  localparam logic [WIDE_W-1:0] CONV_MIN  = WIDE_W'(3);
  localparam logic [WIDE_W-1:0] CONV_MAX  = CNT_MAX + WIDE_W'(3);
  localparam logic [WIDE_W-1:0] FREE_MIN  = WIDE_W'(2);
  localparam logic [WIDE_W-1:0] FREE_MAX  = CNT_MAX + WIDE_W'(2);

  logic [WIDE_W-1:0] conv_v, scan_v, prod, lo, hi;

  always_comb begin
    conv_v = WIDE_W'(conv_q);
    if (conv_v > CONV_MAX) conv_v = CONV_MAX;
    if (conv_v < CONV_MIN) conv_v = CONV_MIN;
    conv_c = conv_timed ? conv_v : '0;
  end

  always_comb begin
    prod = conv_held * WIDE_W'(nchan);
    if (conv_timed) begin
      lo = prod;
      hi = prod + CNT_MAX - WIDE_W'(1);
    end else begin
      lo = FREE_MIN;
      hi = FREE_MAX;
    end
    scan_v = WIDE_W'(scan_q);
    if (scan_v > hi) scan_v = hi;
    if (scan_v < lo) scan_v = lo;
    scan_c = scan_timed ? scan_v : '0;
  end
endmodule

// File: rtl/pace_divisor_calc.sv
module pace_divisor_calc
  import pace_pkg::*;
#(
  parameter int REQ_W  = 32,
  parameter int NCH_W  = 16,
  parameter int CNT_W  = 24,
  parameter int BASE   = 25,
  parameter int WIDE_W = 48,
  localparam int DIV_W = REQ_W + 1,
  localparam int PER_W = WIDE_W + $clog2(BASE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        round_mode,
  input  logic              conv_timed,
  input  logic              scan_timed,
  input  logic [NCH_W-1:0]  nchan,
  input  logic [REQ_W-1:0]  conv_req,
  input  logic [REQ_W-1:0]  scan_req,
  input  logic [REQ_W-1:0]  dac_req,
  output logic              done,
  output logic [WIDE_W-1:0] conv_div,
  output logic [PER_W-1:0]  conv_period,
  output logic [WIDE_W-1:0] scan_div,
  output logic [PER_W-1:0]  scan_period,
  output logic [DIV_W-1:0]  dac_div
);
  localparam int JOB_W = $clog2(NUM_JOBS);
  localparam logic [DIV_W-1:0] DAC_OFS = DIV_W'(2);

  calc_state_e       state;
  round_mode_e       lat_mode;
  logic              lat_conv_timed, lat_scan_timed;
  logic [NCH_W-1:0]  lat_nchan;
  logic [REQ_W-1:0]  lat_req [NUM_JOBS];
  logic [DIV_W-1:0]  num_arr [NUM_JOBS];
  logic [DIV_W-1:0]  q_arr   [NUM_JOBS];
  logic [JOB_W-1:0]  step;
  logic              div_go, div_fin;
  logic [DIV_W-1:0]  div_q;
  logic [WIDE_W-1:0] conv_held;
  logic [WIDE_W-1:0] conv_c, scan_c;
  logic              busy;

  assign busy = (state != ST_IDLE);

  for (genvar g = 0; g < NUM_JOBS; g++) begin : g_round
    pace_round_adj #(.REQ_W(REQ_W), .BASE(BASE)) u_adj (
      .req (lat_req[g]),
      .mode(lat_mode),
      .num (num_arr[g])
    );
  end

  pace_divider #(.DIV_W(DIV_W), .DIVISOR(BASE)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go),
    .dividend(num_arr[step]),
    .fin     (div_fin),
    .quotient(div_q)
  );

  pace_clamp #(.DIV_W(DIV_W), .NCH_W(NCH_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W)) u_clamp (
    .conv_timed(lat_conv_timed),
    .scan_timed(lat_scan_timed),
    .nchan     (lat_nchan),
    .conv_q    (q_arr[JOB_CONV]),
    .scan_q    (q_arr[JOB_SCAN]),
    .conv_held (conv_held),
    .conv_c    (conv_c),
    .scan_c    (scan_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      lat_mode       <= RND_NEAR;
      lat_conv_timed <= 1'b0;
      lat_scan_timed <= 1'b0;
      lat_nchan      <= '0;
      step           <= '0;
      div_go         <= 1'b0;
      conv_held      <= '0;
      done           <= 1'b0;
      conv_div       <= '0;
      conv_period    <= '0;
      scan_div       <= '0;
      scan_period    <= '0;
      dac_div        <= '0;
      for (int i = 0; i < NUM_JOBS; i++) begin
        lat_req[i] <= '0;
        q_arr[i]   <= '0;
      end
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            lat_mode                 <= round_mode_e'(round_mode);
            lat_conv_timed           <= conv_timed;
            lat_scan_timed           <= scan_timed;
            lat_nchan                <= nchan;
            lat_req[JOB_CONV]        <= conv_req;
            lat_req[JOB_SCAN]        <= scan_req;
            lat_req[JOB_DAC]         <= dac_req;
            step                     <= '0;
            div_go                   <= 1'b1;
            state                    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (div_fin) begin
            q_arr[step] <= div_q;
            if (step == JOB_W'(NUM_JOBS - 1)) begin
              state <= ST_FIX_CONV;
            end else begin
              step   <= step + 1'b1;
              div_go <= 1'b1;
            end
          end
        end
        ST_FIX_CONV: begin
          conv_held <= conv_c;
          state     <= ST_FIX_SCAN;
        end
        ST_FIX_SCAN: begin
          conv_div    <= conv_held;
          conv_period <= PER_W'(conv_held) * PER_W'(BASE);
          scan_div    <= scan_c;
          scan_period <= PER_W'(scan_c) * PER_W'(BASE);
          dac_div     <= (q_arr[JOB_DAC] >= DAC_OFS) ? (q_arr[JOB_DAC] - DAC_OFS) : '0;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pace_divisor_calc_chk.sv
module pace_divisor_calc_chk #(
  parameter int REQ_W  = 32,
  parameter int NCH_W  = 16,
  parameter int CNT_W  = 24,
  parameter int WIDE_W = 48,
  parameter int PER_W  = 53
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              lat_conv_timed,
  input logic              lat_scan_timed,
  input logic [NCH_W-1:0]  lat_nchan,
  input logic [REQ_W-1:0]  lat_conv_req,
  input logic [WIDE_W-1:0] conv_div,
  input logic [PER_W-1:0]  conv_period,
  input logic [WIDE_W-1:0] scan_div,
  input logic [PER_W-1:0]  scan_period,
  input logic [REQ_W:0]    dac_div
);
  localparam logic [WIDE_W-1:0] CMAX = WIDE_W'((64'd1 << CNT_W) - 64'd1);
  logic [WIDE_W-1:0] base_lo;
  assign base_lo = conv_div * WIDE_W'(lat_nchan);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(conv_div) && $stable(scan_div) && $stable(dac_div)
               && $stable(conv_period) && $stable(scan_period)));
  // R3
  conv_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lat_conv_timed) |-> (conv_div >= WIDE_W'(3) && conv_div <= CMAX + WIDE_W'(3)));
  // R4
  conv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !lat_conv_timed) |-> (conv_div == '0 && conv_period == '0));
  // R5
  scan_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lat_scan_timed && lat_conv_timed) |->
      (scan_div >= base_lo && scan_div <= base_lo + CMAX - WIDE_W'(1)));
  // R6
  scan_free_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lat_scan_timed && !lat_conv_timed) |->
      (scan_div >= WIDE_W'(2) && scan_div <= CMAX + WIDE_W'(2)));
  // R7
  scan_off_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !lat_scan_timed) |-> (scan_div == '0 && scan_period == '0));
  // R10
  busy_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(lat_conv_req));
endmodule

bind pace_divisor_calc pace_divisor_calc_chk #(
  .REQ_W(REQ_W), .NCH_W(NCH_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W), .PER_W(PER_W)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .lat_conv_timed(lat_conv_timed),
  .lat_scan_timed(lat_scan_timed),
  .lat_nchan     (lat_nchan),
  .lat_conv_req  (lat_req[0]),
  .conv_div      (conv_div),
  .conv_period   (conv_period),
  .scan_div      (scan_div),
  .scan_period   (scan_period),
  .dac_div       (dac_div)
);

// File: tb/test_pace_divisor_calc.sv
module test_pace_divisor_calc;
  localparam int REQ_W  = 32;
  localparam int NCH_W  = 16;
  localparam int CNT_W  = 24;
  localparam int BASE   = 25;
  localparam int WIDE_W = 48;
  localparam int PER_W  = 53;
  localparam longint unsigned MCNT = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        round_mode = '0;
  logic              conv_timed = 1'b0, scan_timed = 1'b0;
  logic [NCH_W-1:0]  nchan = '0;
  logic [REQ_W-1:0]  conv_req = '0, scan_req = '0, dac_req = '0;
  logic              done;
  logic [WIDE_W-1:0] conv_div, scan_div;
  logic [PER_W-1:0]  conv_period, scan_period;
  logic [REQ_W:0]    dac_div;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pace_divisor_calc #(.REQ_W(REQ_W), .NCH_W(NCH_W), .CNT_W(CNT_W), .BASE(BASE), .WIDE_W(WIDE_W))
  i_pace_divisor_calc (
    .clk(clk), .rst(rst), .start(start), .round_mode(round_mode),
    .conv_timed(conv_timed), .scan_timed(scan_timed), .nchan(nchan),
    .conv_req(conv_req), .scan_req(scan_req), .dac_req(dac_req),
    .done(done), .conv_div(conv_div), .conv_period(conv_period),
    .scan_div(scan_div), .scan_period(scan_period), .dac_div(dac_div)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned m_round(longint unsigned ns, bit [1:0] md);
    case (md)
      2'b01:   return (ns + BASE - 1) / BASE;
      2'b10:   return ns / BASE;
      default: return (ns + BASE / 2) / BASE;
    endcase
  endfunction

  task automatic do_op(input bit [31:0] cr, input bit [31:0] sr, input bit [31:0] dr,
                       input bit [1:0] md, input bit ct, input bit st,
                       input bit [15:0] nc, input bit interfere);
    longint unsigned e_conv, e_scan, e_dac, lo, hi, r;
    string tc, ts;
    int w;
    e_conv = 0;
    if (ct) begin
      r = m_round(cr, md);
      if (r > MCNT + 3) r = MCNT + 3;
      if (r < 3) r = 3;
      e_conv = r;
    end
    e_scan = 0;
    if (st) begin
      r = m_round(sr, md);
      if (ct) begin lo = e_conv * nc; hi = e_conv * nc + MCNT - 1; end
      else begin lo = 2; hi = MCNT + 2; end
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      e_scan = r;
    end
    r = m_round(dr, md);
    e_dac = (r >= 2) ? r - 2 : 0;
    tc = ct ? ((md == 2'b11) ? "R2 R3 conv" : "R1 R3 conv") : "R4 conv";
    ts = st ? (ct ? "R5 scan" : "R6 scan") : "R7 scan";

    @(negedge clk);
    conv_req = cr; scan_req = sr; dac_req = dr; round_mode = md;
    conv_timed = ct; scan_timed = st; nchan = nc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (interfere) begin
      repeat (5) @(negedge clk);
      conv_req = ~cr; scan_req = ~sr; dac_req = ~dr; round_mode = md + 2'd1;
      conv_timed = ~ct; scan_timed = ~st; nchan = nc + 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 1000) begin @(negedge clk); w++; end
    if (w >= 1000) chk("R9 done never seen", 0, 1);
    chk(interfere ? "R10 conv_div" : tc, conv_div, e_conv);
    chk(interfere ? "R10 conv_period" : tc, conv_period, e_conv * BASE);
    chk(interfere ? "R10 scan_div" : ts, scan_div, e_scan);
    chk(interfere ? "R10 scan_period" : ts, scan_period, e_scan * BASE);
    chk(interfere ? "R10 dac_div" : "R8 dac_div", dac_div, e_dac);
    @(negedge clk);
    chk("R9 done single cycle", done, 0);
    chk("R9 conv_div hold", conv_div, e_conv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 conv_div", conv_div, 0);
    chk("R11 scan_div", scan_div, 0);
    chk("R11 conv_period", conv_period, 0);
    chk("R11 scan_period", scan_period, 0);
    chk("R11 dac_div", dac_div, 0);

    // R1 rounding boundaries: 112 -> up 5, down 4, near 4 ; 113 -> near 5
    do_op(32'd112, 32'd0, 32'd112, 2'b01, 1'b1, 1'b0, 16'd1, 1'b0);
    do_op(32'd112, 32'd0, 32'd112, 2'b10, 1'b1, 1'b0, 16'd1, 1'b0);
    do_op(32'd112, 32'd0, 32'd112, 2'b00, 1'b1, 1'b0, 16'd1, 1'b0);
    do_op(32'd113, 32'd0, 32'd113, 2'b00, 1'b1, 1'b0, 16'd1, 1'b0);
    // R2 mode 11 acts as nearest
    do_op(32'd113, 32'd300, 32'd113, 2'b11, 1'b1, 1'b1, 16'd1, 1'b0);
    do_op(32'd112, 32'd300, 32'd112, 2'b11, 1'b1, 1'b1, 16'd1, 1'b0);
    // R3 clamps
    do_op(32'd0, 32'd0, 32'd0, 2'b10, 1'b1, 1'b1, 16'd2, 1'b0);
    do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd50, 2'b01, 1'b1, 1'b1, 16'd7, 1'b0);
    // R5 lower and upper scan bound
    do_op(32'd250, 32'd100, 32'd75, 2'b00, 1'b1, 1'b1, 16'd4, 1'b0);
    do_op(32'd250, 32'hFFFF_FFFF, 32'd75, 2'b00, 1'b1, 1'b1, 16'd4, 1'b0);
    do_op(32'd250, 32'd5000, 32'd75, 2'b00, 1'b1, 1'b1, 16'd0, 1'b0);
    // R6 free scan bounds, R4 conversion off
    do_op(32'd900, 32'd0, 32'd75, 2'b00, 1'b0, 1'b1, 16'd4, 1'b0);
    do_op(32'd900, 32'hFFFF_FFFF, 32'd75, 2'b01, 1'b0, 1'b1, 16'd4, 1'b0);
    // R7 scan off
    do_op(32'd900, 32'd5000, 32'd75, 2'b00, 1'b1, 1'b0, 16'd4, 1'b0);
    // R8 saturation and offset
    do_op(32'd90, 32'd0, 32'd10, 2'b10, 1'b1, 1'b0, 16'd1, 1'b0);
    do_op(32'd90, 32'd0, 32'd30, 2'b10, 1'b1, 1'b0, 16'd1, 1'b0);
    do_op(32'd90, 32'd0, 32'd100, 2'b10, 1'b1, 1'b0, 16'd1, 1'b0);
    // R10 start during a running job
    do_op(32'd1000, 32'd40000, 32'd500, 2'b01, 1'b1, 1'b1, 16'd3, 1'b1);
    do_op(32'd7, 32'd77, 32'd777, 2'b10, 1'b0, 1'b1, 16'd9, 1'b1);

    for (int k = 0; k < 300; k++) begin
      bit [31:0] cr, sr, dr;
      case ($urandom % 3)
        0: cr = $urandom % 200;
        1: cr = $urandom % (32'd1 << 20);
        default: cr = $urandom;
      endcase
      case ($urandom % 3)
        0: sr = $urandom % 200;
        1: sr = $urandom % (32'd1 << 26);
        default: sr = $urandom;
      endcase
      dr = ($urandom % 2 == 0) ? ($urandom % 100) : $urandom;
      do_op(cr, sr, dr, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
            16'($urandom % 40), 1'($urandom % 10 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule